// File: doc/BRIEF.md
# Transmit Line Encoder and Load Modulator

This block turns the serial NRZ bit stream of a contactless transponder's frame sequencer into one signal that switches a resistive load across the antenna coil. It has two stages in series. Either stage can be set to pass data through unchanged. The first stage codes the data as NRZ, Manchester or Miller, and an optional inverter sits behind it. The second stage passes the coded level straight through (amplitude keying), runs a half-carrier square wave with phase reversals (two PSK variants), or gates that square wave with the coded level (subcarrier keying).

The block runs on the carrier clock, one cycle per carrier period. The bit timing generator outside the block supplies a one-cycle `bit_stb` at the start of each bit and a one-cycle `half_stb` at mid-bit. `data_in` holds the current bit from its `bit_stb` until the next `bit_stb`. The three mode fields are static while `tx_en` is high. Lowering `tx_en` silences the output and restarts the coder and the square wave. The output changes on the second clock edge after the strobe that causes the change.

Top module: `tx_load_modulator`

## Requirements
- R1: With `enc_sel` 00 or 11 (NRZ), the coded level equals the data bit for the whole bit time.
- R2: With `enc_sel` 01 (Manchester), a 0 is coded high then low and a 1 is coded low then high, with the change at `half_stb`.
- R3: With `enc_sel` 10 (Miller), a 1 toggles the coded level at mid-bit. A 0 that follows a 0 toggles the level at the bit start. A 0 that follows a 1 leaves the level unchanged for the whole bit.
- R4: Miller coding starts from level 0 with a preceding bit of 0 on every rise of `tx_en`. A stream that opens with a 0 and has no inversion is therefore coded 1 for its whole first bit, whatever the earlier transmission left behind.
- R5: With `inv_en` = 1, every coded half-bit level is inverted before the second stage.
- R6: With `mod_sel` 00 (AM), `load_on` equals the coded level. `load_on` changes on the second clock edge after the `bit_stb` or `half_stb` that changes the level, and not on the first.
- R7: With `mod_sel` 01 or 10 (PSK), `load_on` toggles on every carrier clock, except on the clocks where a phase flip skips one toggle.
- R8: In PSK1 (`mod_sel` 01), there is exactly one skipped toggle per bit whose coded level at the bit start is 1, and none otherwise.
- R9: In PSK2 (`mod_sel` 10), there is exactly one skipped toggle for every change of the coded level, whether the change falls at the bit start or at mid-bit.
- R10: In subcarrier mode (`mod_sel` 11), `load_on` toggles every clock while the coded level is 1 and stays 0 while it is 0.
- R11: While `tx_en` is low, `load_on` is 0 from the next clock edge on, whatever the strobes and data do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; low forces the load off and restarts both stages |
| bit_stb | input | 1 | One-cycle pulse at the start of each bit time |
| half_stb | input | 1 | One-cycle pulse at the middle of each bit time |
| data_in | input | 1 | NRZ bit, valid from its `bit_stb` until the next `bit_stb` |
| enc_sel | input | 2 | 00/11 NRZ, 01 Manchester, 10 Miller |
| inv_en | input | 1 | Inverts the coded level before the second stage |
| mod_sel | input | 2 | 00 AM, 01 PSK1, 10 PSK2, 11 subcarrier gating |
| load_on | output | 1 | 1 places the modulation load across the coil |

## Verification
The cycle-level assertions check four things on every clock: the NRZ and Manchester first-half capture, the pass-through of the coded level in AM, the constant toggling in PSK1 between bit starts, and the forced-low output in subcarrier mode or while disabled. The bench scenarios show what no single-cycle property can. These are the Miller state carried from bit to bit and its restart, the exact number of skipped toggles per stream in both PSK variants, the inverted streams, and the two-edge latency from the strobe to the pin.

// File: rtl/txm_pkg.sv
package txm_pkg;
  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] ENC_NRZ   = 2'b00;
  localparam logic [SEL_W-1:0] ENC_MAN   = 2'b01;
  localparam logic [SEL_W-1:0] ENC_MIL   = 2'b10;
  localparam logic [SEL_W-1:0] ENC_NRZ_B = 2'b11;

  localparam logic [SEL_W-1:0] MOD_AM    = 2'b00;
  localparam logic [SEL_W-1:0] MOD_PSK1  = 2'b01;
  localparam logic [SEL_W-1:0] MOD_PSK2  = 2'b10;
  localparam logic [SEL_W-1:0] MOD_SUB   = 2'b11;
endpackage

// File: rtl/txm_encoder.sv
module txm_encoder
  import txm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             bit_stb,
  input  logic             half_stb,
  input  logic             data_in,
  input  logic [SEL_W-1:0] enc_sel,
  input  logic             inv_en,
  output logic             coded
);
  logic raw_q;   // coded level before the inverter
  logic bit_q;   // current bit; doubles as the previous bit at the next bit start

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      raw_q <= 1'b0;
      bit_q <= 1'b0;
    end else if (bit_stb) begin
      bit_q <= data_in;
      case (enc_sel)
        ENC_MAN: raw_q <= ~data_in;
        ENC_MIL: if (!data_in && !bit_q) raw_q <= ~raw_q;
        default: raw_q <= data_in;
      endcase
    end else if (half_stb) begin
      case (enc_sel)
        ENC_MAN: raw_q <= bit_q;
        ENC_MIL: if (bit_q) raw_q <= ~raw_q;
        default: raw_q <= raw_q;
      endcase
    end
  end

  assign coded = raw_q ^ inv_en;

  // R1
  nrz_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && bit_stb && (enc_sel == ENC_NRZ || enc_sel == ENC_NRZ_B))
      |=> (raw_q == $past(data_in)));

  // R2
  man_first_half_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && bit_stb && enc_sel == ENC_MAN) |=> (raw_q == !$past(data_in)));
endmodule

// File: rtl/txm_modulator.sv
module txm_modulator
  import txm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             bit_stb,
  input  logic             coded,
  input  logic [SEL_W-1:0] mod_sel,
  output logic             load_q
);
  logic bs_d;       // bit start, aligned with the new coded level
  logic coded_d;    // coded level one clock earlier
  logic phase_q;    // half-carrier square wave
  logic flip;
  logic phase_n;
  logic load_n;

  always_comb begin
    case (mod_sel)
      MOD_PSK1: flip = bs_d && coded;
      MOD_PSK2: flip = (coded != coded_d);
      default:  flip = 1'b0;
    endcase
    phase_n = flip ? phase_q : ~phase_q;
    case (mod_sel)
      MOD_AM:  load_n = coded;
      MOD_SUB: load_n = coded & phase_n;
      default: load_n = phase_n;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      bs_d    <= 1'b0;
      coded_d <= 1'b0;
      phase_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      bs_d    <= bit_stb;
      coded_d <= coded;
      phase_q <= phase_n;
      load_q  <= load_n;
    end
  end

  // R11
  off_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !load_q);

  // R6
  am_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && mod_sel == MOD_AM) |=> (load_q == $past(coded)));

  // R10
  sub_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && mod_sel == MOD_SUB && !coded) |=> !load_q);

  // R7
  psk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && $past(tx_en) && mod_sel == MOD_PSK1 && $past(mod_sel) == MOD_PSK1 && !bs_d)
      |=> (load_q != $past(load_q)));
endmodule

// File: rtl/tx_load_modulator.sv
module tx_load_modulator
  import txm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             bit_stb,
  input  logic             half_stb,
  input  logic             data_in,
  input  logic [SEL_W-1:0] enc_sel,
  input  logic             inv_en,
  input  logic [SEL_W-1:0] mod_sel,
  output logic             load_on
);
  logic coded;

  txm_encoder u_enc (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .bit_stb  (bit_stb),
    .half_stb (half_stb),
    .data_in  (data_in),
    .enc_sel  (enc_sel),
    .inv_en   (inv_en),
    .coded    (coded)
  );

  txm_modulator u_mod (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .bit_stb  (bit_stb),
    .coded    (coded),
    .mod_sel  (mod_sel),
    .load_q   (load_on)
  );
endmodule

// File: tb/tx_load_modulator_test.sv
module tx_load_modulator_test;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 8;

  logic       clk = 1'b0;
  logic       rst, tx_en, bit_stb, half_stb, data_in, inv_en;
  logic [1:0] enc_sel, mod_sel;
  logic       load_on;

  int n_cmp = 0;
  int n_bad = 0;
  logic samp [0:135];
  logic lv   [0:31];

  tx_load_modulator uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bit_stb(bit_stb), .half_stb(half_stb),
    .data_in(data_in), .enc_sel(enc_sel), .inv_en(inv_en), .mod_sel(mod_sel),
    .load_on(load_on)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected coded half-bit levels from the coding rules.
  task automatic model(input logic [1:0] e, input logic iv, input logic [15:0] bits, input int n);
    logic s, p, bt, f, sc;
    s = 1'b0; p = 1'b0;
    for (int b = 0; b < n; b++) begin
      bt = bits[n-1-b];
      case (e)
        2'b01: begin f = ~bt; sc = bt; end
        2'b10: begin
          if (!bt && !p) s = ~s;
          f = s;
          if (bt) s = ~s;
          sc = s;
        end
        default: begin f = bt; sc = bt; end
      endcase
      p = bt;
      lv[2*b]   = f ^ iv;
      lv[2*b+1] = sc ^ iv;
    end
  endtask

  // Sends a stream after a restart; samp[b*8+c] is taken before cycle c of bit b is driven.
  task automatic run(input logic [1:0] e, input logic iv, input logic [1:0] m,
                     input logic [15:0] bits, input int n);
    @(negedge clk);
    tx_en = 1'b0; bit_stb = 1'b0; half_stb = 1'b0;
    repeat (2) @(negedge clk);
    enc_sel = e; inv_en = iv; mod_sel = m;
    for (int b = 0; b < n; b++) begin
      for (int c = 0; c < BIT_CLKS; c++) begin
        if (!(b == 0 && c == 0)) @(negedge clk);
        samp[b*BIT_CLKS+c] = load_on;
        tx_en    = 1'b1;
        bit_stb  = (c == 0);
        half_stb = (c == BIT_CLKS/2);
        data_in  = bits[n-1-b];
      end
    end
    @(negedge clk);
    samp[n*BIT_CLKS] = load_on;
    bit_stb = 1'b0; half_stb = 1'b0;
    model(e, iv, bits, n);
  endtask

  task automatic check_levels(input string tag, input int n);
    for (int b = 0; b < n; b++) begin
      chk(tag, samp[b*BIT_CLKS+3], lv[2*b]);
      chk(tag, samp[b*BIT_CLKS+7], lv[2*b+1]);
    end
  endtask

  function automatic int count_holds(input int n);
    int h = 0;
    for (int i = 1; i < n*BIT_CLKS; i++)
      if (samp[i+1] == samp[i]) h++;
    return h;
  endfunction

  task automatic t_reset();
    chk("R11 reset", load_on, 1'b0);
  endtask

  task automatic t_nrz();
    logic prev;
    run(2'b00, 1'b0, 2'b00, 16'b1011_0010, 8);
    check_levels("R1 NRZ 00", 8);
    // R6: level visible after the second edge, not the first
    prev = 1'b0;
    for (int b = 0; b < 8; b++) begin
      if (lv[2*b] != prev) begin
        chk("R6 latency first edge", samp[b*BIT_CLKS+1], prev);
        chk("R6 latency second edge", samp[b*BIT_CLKS+2], lv[2*b]);
      end
      prev = lv[2*b+1];
    end
    run(2'b11, 1'b0, 2'b00, 16'b0110_1001, 8);
    check_levels("R1 NRZ 11", 8);
  endtask

  task automatic t_man();
    run(2'b01, 1'b0, 2'b00, 16'b1100_1010, 8);
    check_levels("R2 Manchester", 8);
    chk("R2 one low first", samp[3], 1'b0);
    chk("R2 one high second", samp[7], 1'b1);
  endtask

  task automatic t_miller();
    run(2'b10, 1'b0, 2'b00, 16'b0011_0100, 8);
    check_levels("R3 Miller", 8);
    // R4: leave state high, then restart with a leading 0
    run(2'b10, 1'b0, 2'b00, 16'b1, 1);
    chk("R4 prior run ends high", samp[7], 1'b1);
    run(2'b10, 1'b0, 2'b00, 16'b0010, 4);
    chk("R4 first half", samp[3], 1'b1);
    chk("R4 second half", samp[7], 1'b1);
    check_levels("R4 restart stream", 4);
  endtask

  task automatic t_inv();
    run(2'b01, 1'b1, 2'b00, 16'b1001_1101, 8);
    check_levels("R5 inverted Manchester", 8);
    run(2'b10, 1'b1, 2'b00, 16'b0101_1000, 8);
    check_levels("R5 inverted Miller", 8);
    chk("R5 Miller start inverted", samp[3], 1'b0);
  endtask

  task automatic t_psk1();
    int ones = 0;
    run(2'b00, 1'b0, 2'b01, 16'b1011_0111, 8);
    for (int b = 0; b < 8; b++) if (lv[2*b]) ones++;
    chk_int("R8 PSK1 skipped toggles", count_holds(8), ones);
    chk_int("R7 PSK1 toggle count", 8*BIT_CLKS - 1 - count_holds(8), 8*BIT_CLKS - 1 - ones);
  endtask

  task automatic t_psk2();
    int ch = 0;
    logic p = 1'b0;
    run(2'b01, 1'b0, 2'b10, 16'b0110_1000, 8);
    for (int i = 0; i < 16; i++) begin
      if (lv[i] != p) ch++;
      p = lv[i];
    end
    chk_int("R9 PSK2 Manchester flips", count_holds(8), ch);
    ch = 0; p = 1'b0;
    run(2'b00, 1'b0, 2'b10, 16'b1100_0101, 8);
    for (int i = 0; i < 16; i++) begin
      if (lv[i] != p) ch++;
      p = lv[i];
    end
    chk_int("R9 PSK2 NRZ flips", count_holds(8), ch);
    chk_int("R7 PSK2 toggles", 8*BIT_CLKS - 1 - count_holds(8), 8*BIT_CLKS - 1 - ch);
  endtask

  task automatic t_sub();
    run(2'b10, 1'b0, 2'b11, 16'b1001_0110, 8);
    for (int b = 0; b < 8; b++) begin
      for (int h = 0; h < 2; h++) begin
        int i = b*BIT_CLKS + 2 + 4*h;
        if (lv[2*b+h]) chk("R10 gated toggling", samp[i+1] != samp[i], 1'b1);
        else begin
          chk("R10 quiet", samp[i], 1'b0);
          chk("R10 quiet", samp[i+1], 1'b0);
        end
      end
    end
  endtask

  task automatic t_disable();
    run(2'b00, 1'b0, 2'b00, 16'hFFFF, 4);
    chk("R11 on before drop", load_on, 1'b1);
    tx_en = 1'b0; data_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R11 off while disabled", load_on, 1'b0);
      bit_stb  = (k % 2 == 0);
      half_stb = (k % 2 == 1);
    end
    bit_stb = 1'b0; half_stb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tx_en = 1'b0; bit_stb = 1'b0; half_stb = 1'b0; data_in = 1'b0;
    inv_en = 1'b0; enc_sel = 2'b00; mod_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nrz();
    t_man();
    t_miller();
    t_inv();
    t_psk1();
    t_psk2();
    t_sub();
    t_disable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule